// File: doc/BRIEF.md
# Rate Adaptation IDLE-Deleting FIFO

This block sits between the source of 8-bit line codes (one code per clock, each with a control flag) and the 64b/66b encoder of a burst-mode upstream transmitter. While the forward error correction stage inserts parity blocks, it raises a parity-insertion input. For those cycles the downstream path stops and nothing is sent. Codes that keep arriving are held in a small queue.

Once insertion ends, the queue is drained from its head at one code per cycle while new codes go on arriving at the same rate. The backlog shrinks because every arriving IDLE is dropped whenever it cannot go straight through. When the queue is empty and insertion is off, codes pass straight to the output in the same cycle, IDLEs included. An empty-queue status lets the laser control wait for the backlog to clear before ending a burst. The block is held cleared outside the data phase of a burst. A sticky overflow flag reports a backlog deeper than the configured depth.

Top module: `ra_idle_fifo`

## Requirements
- R1: A code is an IDLE only when its control flag is 1 and its data byte is 8'h07. Only IDLEs are ever dropped. A non-control 8'h07 and any other control byte are kept like data.
- R2: With `data_phase` high, `fec_insert` low and the queue empty, the input code appears on the output in the same cycle with `out_vld` high. This includes IDLEs.
- R3: While `fec_insert` is high, `out_vld` is low. Arriving non-IDLE codes are appended to the queue tail and arriving IDLEs are dropped.
- R4: With `fec_insert` low and the queue non-empty, the output shows the queue head with `out_vld` high and one code is dequeued per cycle. Arriving non-IDLE codes are appended and arriving IDLEs are dropped.
- R5: Non-IDLE codes leave the block in the order they arrived.
- R6: `fifo_empty` is high exactly when the queue holds no code, as updated at each clock edge.
- R7: A non-IDLE code that must be queued while the queue holds DEPTH codes and no code leaves that cycle is discarded, and `overflow` is set. It stays set until `data_phase` goes low or reset.
- R8: While `data_phase` is low, `out_vld` is low and input codes are ignored. At the next edge the queue is emptied and `overflow` is cleared.
- R9: After reset, `fifo_empty` is high, `overflow` is low and no code is queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_phase | input | 1 | High during the data phase of a burst; low clears and idles the block |
| fec_insert | input | 1 | Parity insertion active: stop output and buffer input |
| in_ctrl | input | 1 | Control flag of the arriving code |
| in_data | input | 8 | Byte of the arriving code |
| out_vld | output | 1 | A code is sent to the encoder this cycle |
| out_ctrl | output | 1 | Control flag of the sent code |
| out_data | output | 8 | Byte of the sent code |
| fifo_empty | output | 1 | Queue holds no code |
| overflow | output | 1 | Sticky: a code was lost because the queue was full |

## Verification
The assertions assume that the input stream is a code on every cycle and that `fec_insert` only changes synchronously. They also assume that a queue push is never requested for an IDLE. The steering logic and the queue are separate modules, so that last assumption is a real check across their boundary. The stimulus drives inputs only at falling edges and keeps `data_phase` high through most of the run. It drops `data_phase` deliberately in a few places to test clearing. Random insertion pulses are short enough that the IDLE share of the traffic drains the backlog. One directed pulse overruns the depth on purpose.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } xcode_t;

    localparam logic [7:0] IDLE_CHAR = 8'h07;

    function automatic logic is_idle(input xcode_t c);
        return c.ctrl && (c.data == IDLE_CHAR);
    endfunction

endpackage

// File: rtl/ra_queue.sv
module ra_queue
    import ra_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   clr,
    input  logic   push,
    input  logic   pop,
    input  xcode_t din,
    output xcode_t head,
    output logic   empty,
    output logic   full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    xcode_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R1: the steering logic must never store an IDLE
    p_idle_never_stored_r1: assert property (@(posedge clk) disable iff (clr)
        push |-> !is_idle(din));

    // R4: a dequeue only happens from a non-empty queue
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (clr)
        pop |-> !empty);

    // R7: occupancy never exceeds the depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (clr)
        count <= CW'(DEPTH));

endmodule

// File: rtl/ra_steer.sv
module ra_steer
    import ra_pkg::*;
(
    input  logic   data_phase,
    input  logic   fec_insert,
    input  xcode_t in_code,
    input  logic   q_empty,
    input  logic   q_full,
    output logic   push,
    output logic   pop,
    output logic   lost,
    output logic   send,
    output logic   from_queue
);
    logic flowing;
    logic need_store;

    always_comb begin
        flowing    = data_phase && !fec_insert;
        send       = flowing;
        from_queue = !q_empty;
        pop        = flowing && !q_empty;
        // a code must be stored unless it goes straight out; IDLEs never are
        need_store = data_phase && !(flowing && q_empty) && !is_idle(in_code);
        push       = need_store && (!q_full || pop);
        lost       = need_store && q_full && !pop;
    end

endmodule

// File: rtl/ra_idle_fifo.sv
module ra_idle_fifo
    import ra_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_phase,
    input  logic       fec_insert,
    input  logic       in_ctrl,
    input  logic [7:0] in_data,
    output logic       out_vld,
    output logic       out_ctrl,
    output logic [7:0] out_data,
    output logic       fifo_empty,
    output logic       overflow
);
    xcode_t in_code;
    xcode_t head;
    xcode_t out_code;
    logic   q_empty, q_full;
    logic   push, pop, lost, send, from_queue;
    logic   clr;

    assign in_code = '{ctrl: in_ctrl, data: in_data};
    assign clr     = rst || !data_phase;

    ra_steer u_steer (
        .data_phase (data_phase),
        .fec_insert (fec_insert),
        .in_code    (in_code),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .push       (push),
        .pop        (pop),
        .lost       (lost),
        .send       (send),
        .from_queue (from_queue)
    );

    ra_queue #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .clr   (clr),
        .push  (push),
        .pop   (pop),
        .din   (in_code),
        .head  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (clr)       overflow <= 1'b0;
        else if (lost) overflow <= 1'b1;
    end

    assign out_code   = from_queue ? head : in_code;
    assign out_vld    = send;
    assign out_ctrl   = out_code.ctrl;
    assign out_data   = out_code.data;
    assign fifo_empty = q_empty;

    // R3: nothing is sent while parity insertion runs
    p_silent_insert_r3: assert property (@(posedge clk) disable iff (rst)
        fec_insert |-> !out_vld);

    // R7: overflow is sticky within the data phase
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (overflow && data_phase) |=> overflow);

    // R8: leaving the data phase empties the queue
    p_phase_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !data_phase |=> (fifo_empty && !overflow));

    // R2: an empty queue with insertion off forwards the input unchanged
    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        (data_phase && !fec_insert && fifo_empty) |->
            (out_vld && out_ctrl == in_ctrl && out_data == in_data));

endmodule

// File: tb/ra_idle_fifo_test.sv
module ra_idle_fifo_test;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_phase = 1'b0;
    logic       fec_insert = 1'b0;
    logic       in_ctrl = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_vld, out_ctrl, fifo_empty, overflow;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [8:0] mq[$];
    logic       movf = 1'b0;

    always #5 clk = ~clk;

    ra_idle_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .data_phase(data_phase), .fec_insert(fec_insert),
        .in_ctrl(in_ctrl), .in_data(in_data), .out_vld(out_vld), .out_ctrl(out_ctrl),
        .out_data(out_data), .fifo_empty(fifo_empty), .overflow(overflow)
    );

    function automatic bit idle_of(input logic [8:0] c);
        return c[8] && (c[7:0] == 8'h07);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at falling edge, check before rising edge, update model
    task automatic step(input logic c, input logic [7:0] d, input logic ins,
                        input logic ph, input string tag);
        logic [8:0] code;
        logic       ev;
        bit         pass_q, pop_q, full_q, store;
        @(negedge clk);
        in_ctrl = c; in_data = d; fec_insert = ins; data_phase = ph;
        code = {c, d};
        #1;
        ev = ph && !ins;
        check(ins ? "R3 out_vld" : (ph ? "R2/R4 out_vld" : "R8 out_vld"),
              {31'd0, out_vld}, {31'd0, ev});
        if (ev) begin
            if (mq.size() == 0)
                check({"R2 passthru ", tag}, {23'd0, out_ctrl, out_data}, {23'd0, code});
            else
                check({"R4/R5 head ", tag}, {23'd0, out_ctrl, out_data}, {23'd0, mq[0]});
        end
        check("R6 fifo_empty", {31'd0, fifo_empty}, {31'd0, mq.size() == 0});
        check("R7 overflow", {31'd0, overflow}, {31'd0, movf});
        @(posedge clk);
        if (rst || !ph) begin
            mq.delete();
            movf = 1'b0;
        end else begin
            pass_q = !ins && mq.size() == 0;
            pop_q  = !ins && mq.size() != 0;
            full_q = mq.size() == DEPTH;
            store  = !pass_q && !idle_of(code);
            if (pop_q) void'(mq.pop_front());
            if (store) begin
                if (!full_q || pop_q) mq.push_back(code);
                else movf = 1'b1;
            end
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R9: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 fifo_empty", {31'd0, fifo_empty}, 32'd1);
        check("R9 overflow", {31'd0, overflow}, 32'd0);
        rst = 1'b0;

        // R2: passthrough, IDLE included
        step(1'b1, 8'h07, 1'b0, 1'b1, "R2 idle");
        step(1'b0, 8'hA5, 1'b0, 1'b1, "R2 data");

        // R3/R1: insertion, with a non-control 0x07 and a control non-IDLE kept
        step(1'b0, 8'h07, 1'b1, 1'b1, "R1");
        step(1'b1, 8'h07, 1'b1, 1'b1, "R3 idle");
        step(1'b1, 8'hFB, 1'b1, 1'b1, "R1");
        step(1'b0, 8'h11, 1'b1, 1'b1, "R3");
        // R4/R5: drain by IDLE deletion
        for (int i = 0; i < 6; i++) step(1'b1, 8'h07, 1'b0, 1'b1, "R5 drain");
        check("R6 drained", {31'd0, fifo_empty}, 32'd1);

        // R7: overrun the depth
        for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 8'(i), 1'b1, 1'b1, "R7 fill");
        step(1'b0, 8'h55, 1'b0, 1'b1, "R7 hold");
        check("R7 sticky", {31'd0, overflow}, 32'd1);
        // R8: leave data phase
        step(1'b0, 8'h66, 1'b0, 1'b0, "R8");
        step(1'b0, 8'h77, 1'b1, 1'b0, "R8");
        step(1'b1, 8'h07, 1'b0, 1'b1, "R8 after");

        // random: insertion pulses with mixed traffic
        for (int b = 0; b < 300; b++) begin
            int ilen = $urandom_range(1, 8);
            int glen = $urandom_range(4, 24);
            for (int i = 0; i < ilen + glen; i++) begin
                logic c; logic [7:0] d;
                if ($urandom_range(0, 99) < 60) begin c = 1'b1; d = 8'h07; end
                else begin c = ($urandom_range(0, 3) == 0); d = 8'($urandom); end
                step(c, d, i < ilen, ($urandom_range(0, 199) != 0), "R5 rand");
            end
        end
        done = 1;
        summary();
        $finish;
    end
endmodule